// File: doc/BRIEF.md
# Bit-serial reflected CRC-32 / Castagnoli update unit

This unit advances a CRC state that sits in one register-wide operand. A start pulse captures the operand, a size code and a polynomial select. The unit then runs the least-significant-bit-first CRC step once per clock for 8, 16, 32 or 64 steps. In each step the value moves right by one place. When the bit that falls out is 1, the fixed 32-bit reflected polynomial, zero-extended to the register width, is XORed into the shifted value. The unit then returns the updated value together with a single-cycle done pulse.

The unit behaves like a single-source, single-destination execution slot. The caller supplies the current CRC register contents and later collects the result. The caller is responsible for seeding, for final inversion and for ordering the message bytes. The register width is a parameter of at least 32. The 64-step size exists only when the width is greater than 32.

Top module: `crc_step_unit`

## Requirements
- R1: While rst_n is low at a clock edge, busy_o, done_o and result_o are all cleared to zero in the following cycle.
- R2: One step replaces value v with (v >> 1) XOR (v[0] ? P : 0). With poly_sel_i = 0, P is 0xEDB88320 zero-extended. For example, 0x80 over 8 steps gives 0xEDB88320.
- R3: With poly_sel_i = 1, P is 0x82F63B78 zero-extended. The select is captured at start and has no effect while an operation runs.
- R4: size_i codes 2'b00, 2'b01, 2'b10 and 2'b11 select 8, 16, 32 and 64 steps. done_o rises exactly N clock edges after the edge that accepts start_i.
- R5: When XLEN is 32, size code 2'b11 performs 32 steps.
- R6: A start_i pulse while busy_o is high is ignored. The running operation keeps its operand, its result and its latency.
- R7: done_o is high for exactly one cycle. result_o holds the final value unchanged until the next accepted start.
- R8: busy_o is high from the cycle after an accepted start until done_o rises. busy_o and done_o are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start_i | input | 1 | Start pulse, accepted when not busy |
| value_i | input | XLEN | Current CRC state operand |
| size_i | input | 2 | Step count code (00=8, 01=16, 10=32, 11=64) |
| poly_sel_i | input | 1 | 0 = CRC-32 polynomial, 1 = Castagnoli polynomial |
| result_o | output | XLEN | Updated CRC state |
| done_o | output | 1 | One-cycle completion pulse |
| busy_o | output | 1 | Operation in progress |

## Verification
The hardest case to reach from the ports is a start pulse that lands in the middle of a running operation. It arrives with a different operand, size and polynomial, and the bench must show that none of them leak into the result or the latency. The stimulus first launches a long 32-step operation. It then pulses start several cycles in, with conflicting inputs, and requires the original result at exactly the original step count. A second instance at 32-bit width receives the 64-step code to cover the reduced-width mapping.

// File: rtl/crc_step_pkg.sv
// Package: shared constants and helpers for the bit-serial CRC unit.
// Assumes the register width parameter is at least 32.
package crc_step_pkg;

    typedef enum logic [1:0] {
        SZ_8  = 2'b00,
        SZ_16 = 2'b01,
        SZ_32 = 2'b10,
        SZ_64 = 2'b11
    } crc_size_e;

    localparam logic [31:0] POLY_STD  = 32'hEDB8_8320;
    localparam logic [31:0] POLY_CAST = 32'h82F6_3B78;

    // Largest step count the datapath supports for a given width.
    function automatic int unsigned max_steps(input int unsigned xlen);
        return (xlen > 32) ? 64 : 32;
    endfunction

endpackage

// File: rtl/crc_step_poly_sel.sv
// Module: captures the polynomial select at start and presents the chosen
// reflected polynomial, zero-extended to the datapath width.
// Assumes XLEN >= 32.
module crc_step_poly_sel
    import crc_step_pkg::*;
#(
    parameter int unsigned XLEN = 64
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            load_i,
    input  logic            busy_i,
    input  logic            sel_i,
    output logic [XLEN-1:0] poly_o
);

    logic sel_q;

    // Hold the selection for the lifetime of one operation.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sel_q <= 1'b0;
        end else if (load_i) begin
            sel_q <= sel_i;
        end
    end

    // Drive the widened polynomial constant.
    always_comb begin
        poly_o = sel_q ? XLEN'(POLY_CAST) : XLEN'(POLY_STD);
    end

    // R3
    poly_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_i && !load_i) |=> $stable(sel_q));

endmodule

// File: rtl/crc_step_ctrl.sv
// Module: step counter and handshake. It accepts start only when idle,
// loads the step count from the size code, counts down once per clock, and
// pulses done on the edge that performs the final step.
// Assumes XLEN >= 32. Code 11 maps to 32 steps when XLEN is 32.
module crc_step_ctrl
    import crc_step_pkg::*;
#(
    parameter int unsigned XLEN = 64
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       start_i,
    input  logic [1:0] size_i,
    output logic       load_o,
    output logic       step_o,
    output logic       busy_o,
    output logic       done_o
);

    localparam int unsigned MAX_ITER = max_steps(XLEN);
    localparam int unsigned CNT_W    = $clog2(MAX_ITER + 1);

    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] n_iter;
    logic             busy_q;
    logic             done_q;

    // Translate the size code into a step count.
    always_comb begin
        unique case (crc_size_e'(size_i))
            SZ_8:    n_iter = CNT_W'(8);
            SZ_16:   n_iter = CNT_W'(16);
            SZ_32:   n_iter = CNT_W'(32);
            default: n_iter = CNT_W'(MAX_ITER);
        endcase
    end

    // Start is honoured only while idle.
    always_comb begin
        load_o = start_i && !busy_q;
        step_o = busy_q;
    end

    // Count steps and raise the completion pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy_q <= 1'b0;
            done_q <= 1'b0;
            cnt_q  <= '0;
        end else begin
            done_q <= 1'b0;
            if (load_o) begin
                busy_q <= 1'b1;
                cnt_q  <= n_iter;
            end else if (busy_q) begin
                cnt_q <= cnt_q - CNT_W'(1);
                if (cnt_q == CNT_W'(1)) begin
                    busy_q <= 1'b0;
                    done_q <= 1'b1;
                end
            end
        end
    end

    assign busy_o = busy_q;
    assign done_o = done_q;

    // R7
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_q |=> !done_q);

    // R8
    done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_q |-> !busy_q);

    // R6
    busy_start_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_q && start_i && cnt_q > CNT_W'(1)) |=>
            (busy_q && cnt_q == $past(cnt_q) - CNT_W'(1)));

    // R4
    cnt_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= CNT_W'(MAX_ITER));

endmodule

// File: rtl/crc_step_datapath.sv
// Module: the CRC state register and its one-bit reflected update.
// On load it takes the operand. On each step it shifts right and folds in
// the polynomial when the dropped bit is set. Otherwise it holds.
module crc_step_datapath #(
    parameter int unsigned XLEN = 64
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            load_i,
    input  logic            step_i,
    input  logic [XLEN-1:0] value_i,
    input  logic [XLEN-1:0] poly_i,
    output logic [XLEN-1:0] state_o
);

    logic [XLEN-1:0] state_q;
    logic [XLEN-1:0] state_nx;

    // One LSB-first division step.
    always_comb begin
        state_nx = {1'b0, state_q[XLEN-1:1]} ^ (state_q[0] ? poly_i : '0);
    end

    // Load, advance or hold the CRC state.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= '0;
        end else if (load_i) begin
            state_q <= value_i;
        end else if (step_i) begin
            state_q <= state_nx;
        end
    end

    assign state_o = state_q;

    // R7
    state_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!load_i && !step_i) |=> $stable(state_q));

    // R2
    step_top_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (step_i && !load_i && !state_q[XLEN-1] && XLEN > 32) |=> !state_q[XLEN-1]);

endmodule

// File: rtl/crc_step_unit.sv
// Module: top of the bit-serial reflected CRC update unit. It ties the
// controller, the polynomial selector and the state datapath together.
// Assumes XLEN >= 32 and that the caller waits for done before reading.
module crc_step_unit #(
    parameter int unsigned XLEN = 64
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            start_i,
    input  logic [XLEN-1:0] value_i,
    input  logic [1:0]      size_i,
    input  logic            poly_sel_i,
    output logic [XLEN-1:0] result_o,
    output logic            done_o,
    output logic            busy_o
);

    logic            load;
    logic            step;
    logic            busy;
    logic [XLEN-1:0] poly;

    crc_step_ctrl #(.XLEN(XLEN)) u_ctrl (
        .clk     (clk),
        .rst_n   (rst_n),
        .start_i (start_i),
        .size_i  (size_i),
        .load_o  (load),
        .step_o  (step),
        .busy_o  (busy),
        .done_o  (done_o)
    );

    crc_step_poly_sel #(.XLEN(XLEN)) u_poly (
        .clk    (clk),
        .rst_n  (rst_n),
        .load_i (load),
        .busy_i (busy),
        .sel_i  (poly_sel_i),
        .poly_o (poly)
    );

    crc_step_datapath #(.XLEN(XLEN)) u_dp (
        .clk     (clk),
        .rst_n   (rst_n),
        .load_i  (load),
        .step_i  (step),
        .value_i (value_i),
        .poly_i  (poly),
        .state_o (result_o)
    );

    assign busy_o = busy;

    // R8
    busy_after_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (start_i && !busy) |=> busy_o);

endmodule

// File: tb/crc_step_unit_tb.sv
module crc_step_unit_tb;

    localparam int CLK_PERIOD = 10;
    localparam int NVEC = 10;

    localparam logic [63:0] VEC_VAL [NVEC] = '{
        64'h0000_0000_0000_0080, 64'h0000_0000_0000_0080,
        64'h0000_0000_0000_0000, 64'hFFFF_FFFF_FFFF_FFFF,
        64'h0123_4567_89AB_CDEF, 64'hDEAD_BEEF_0000_0061,
        64'h8000_0000_0000_0000, 64'h0000_0000_1234_5678,
        64'hA5A5_5A5A_C3C3_3C3C, 64'h0000_0000_FFFF_0000
    };
    localparam logic [1:0] VEC_SIZE [NVEC] = '{
        2'b00, 2'b00, 2'b10, 2'b11, 2'b01, 2'b00, 2'b11, 2'b10, 2'b11, 2'b01
    };
    localparam logic VEC_POLY [NVEC] = '{
        1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 1'b1, 1'b1, 1'b0
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [63:0] value = '0;
    logic [1:0]  size = '0;
    logic        psel = 1'b0;
    logic [63:0] result;
    logic        done;
    logic        busy;

    logic        start32 = 1'b0;
    logic [31:0] value32 = '0;
    logic [31:0] result32;
    logic        done32;
    logic        busy32;

    int checks = 0;
    int failures = 0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    crc_step_unit #(.XLEN(64)) u_dut (
        .clk(clk), .rst_n(rst_n), .start_i(start), .value_i(value),
        .size_i(size), .poly_sel_i(psel), .result_o(result),
        .done_o(done), .busy_o(busy)
    );

    crc_step_unit #(.XLEN(32)) u_dut32 (
        .clk(clk), .rst_n(rst_n), .start_i(start32), .value_i(value32),
        .size_i(2'b11), .poly_sel_i(1'b0), .result_o(result32),
        .done_o(done32), .busy_o(busy32)
    );

    function automatic int steps_of(input logic [1:0] code);
        case (code)
            2'b00:   return 8;
            2'b01:   return 16;
            2'b10:   return 32;
            default: return 64;
        endcase
    endfunction

    function automatic logic [63:0] crc_ref(input logic [63:0] v, input int n,
                                            input logic sel);
        logic [63:0] p = sel ? 64'h82F6_3B78 : 64'hEDB8_8320;
        for (int i = 0; i < n; i++) v = (v >> 1) ^ (v[0] ? p : 64'h0);
        return v;
    endfunction

    task automatic check(input string req, input logic [63:0] act,
                         input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic run_op(input logic [63:0] v, input logic [1:0] c, input logic s,
                          output int lat);
        @(negedge clk);
        value = v; size = c; psel = s; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        check("R8 busy after start", {63'h0, busy}, 64'h1);
        lat = 0;
        for (int k = 0; k < 200; k++) begin
            @(negedge clk);
            lat++;
            if (busy && done) check("R8 busy/done overlap", 64'h1, 64'h0);
            if (done) break;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        checks++;
        failures++;
        $display("FAIL watchdog actual=hung expected=finish");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        int lat;
        logic [63:0] held;
        repeat (3) @(negedge clk);
        // R1 reset state
        check("R1 busy", {63'h0, busy}, 64'h0);
        check("R1 done", {63'h0, done}, 64'h0);
        check("R1 result", result, 64'h0);
        rst_n = 1'b1;

        // Vector table: R2, R3, R4
        for (int i = 0; i < NVEC; i++) begin
            run_op(VEC_VAL[i], VEC_SIZE[i], VEC_POLY[i], lat);
            check(VEC_POLY[i] ? "R3 result" : "R2 result", result,
                  crc_ref(VEC_VAL[i], steps_of(VEC_SIZE[i]), VEC_POLY[i]));
            check("R4 latency", 64'(lat), 64'(steps_of(VEC_SIZE[i])));
        end

        // R2 hand value: 0x80 over 8 steps yields the polynomial itself
        run_op(64'h80, 2'b00, 1'b0, lat);
        check("R2 hand poly", result, 64'hEDB8_8320);
        // R3 hand value for the Castagnoli polynomial
        run_op(64'h80, 2'b00, 1'b1, lat);
        check("R3 hand poly", result, 64'h82F6_3B78);
        // R4 64-step hand value
        run_op(64'h8000_0000_0000_0000, 2'b11, 1'b0, lat);
        check("R4 64-step poly", result, 64'hEDB8_8320);

        // R7 pulse width and hold
        held = result;
        @(negedge clk);
        check("R7 done pulse", {63'h0, done}, 64'h0);
        repeat (4) @(negedge clk);
        value = 64'h5555; psel = 1'b1;
        @(negedge clk);
        check("R7 result hold", result, held);

        // R6 start while busy ignored; R3 select change mid-run ignored
        @(negedge clk);
        value = 64'h0000_0000_CAFE_F00D; size = 2'b10; psel = 1'b0; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        lat = 0;
        repeat (3) begin @(negedge clk); lat++; end
        value = 64'hFFFF; size = 2'b00; psel = 1'b1; start = 1'b1;
        @(negedge clk); lat++;
        start = 1'b0;
        for (int k = 0; k < 200; k++) begin
            if (done) break;
            @(negedge clk);
            lat++;
        end
        check("R6 result", result, crc_ref(64'h0000_0000_CAFE_F00D, 32, 1'b0));
        check("R6 latency", 64'(lat), 64'd32);

        // R5 narrow width, code 11 runs 32 steps
        @(negedge clk);
        value32 = 32'h8000_0000; start32 = 1'b1;
        @(negedge clk);
        start32 = 1'b0;
        lat = 0;
        for (int k = 0; k < 200; k++) begin
            @(negedge clk);
            lat++;
            if (done32) break;
        end
        check("R5 latency", 64'(lat), 64'd32);
        check("R5 result", {32'h0, result32}, 64'hEDB8_8320);

        // R1 reset in mid-operation
        run_op(64'h1234, 2'b11, 1'b0, lat);
        @(negedge clk);
        value = 64'h9; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        rst_n = 1'b0;
        @(negedge clk);
        check("R1 mid reset busy", {63'h0, busy}, 64'h0);
        check("R1 mid reset result", result, 64'h0);
        rst_n = 1'b1;

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule